// File: doc/BRIEF.md
# Dual-Mode Tune Command Receiver

This block is the digital front end of a tunable device. A host sends it a 16-bit tune command in one of two ways. The first is a write-only three-wire serial link: an active-low select, a clock and a data input, in SPI mode 0 with the most significant bit first. The second is an 8-bit parallel bus clocked by a strobe, where the word arrives as a high byte and then a low byte. Both interfaces use one set of pins. In serial mode, bus bit 7 carries the serial clock and bus bit 5 carries the serial data. The strobe pin is the select line, tied to chip select. A strap input chooses the interface. The block samples the strap once, on the first clock after reset is released, and holds that choice until the next reset.

A falling strobe wakes the block and raises `readyOut`. The command is then framed and checked. Bits 15..10 must be zero. Bits 9..8 are the band code. Bits 7..0 are the step index. A legal command is published on `bandOut` and `codeOut` together with a one-cycle `tunePulse`, and starts a modelled busy period. An illegal command sets a sticky error flag. In parallel mode, holding the strobe low for a long time while the low byte is awaited cancels the half-loaded transfer.

Top module: `tune_cmd_rx`

## Requirements
- R1: During and after reset, `readyOut`, `tunePulse`, `busyOut` and `errFlag` are 0, and `bandOut` and `codeOut` are 0.
- R2: In serial mode, the block shifts in exactly 16 bits on rising edges of bus bit 7, sampling bus bit 5, most significant bit first. When the strobe rises after such a frame and the word is legal, `bandOut` takes word bits 9..8, `codeOut` takes word bits 7..0, and `tunePulse` is high for exactly one cycle.
- R3: In serial mode, a frame that ends with a bit count other than 16 is discarded. No `tunePulse` is issued, `bandOut`, `codeOut` and `errFlag` are unchanged, and `readyOut` returns to 0.
- R4: In parallel mode, after the waking strobe fall, the first strobe rise latches the bus as word bits 15..8. The second strobe rise latches the bus as bits 7..0 and starts evaluation of the word.
- R5: A word with any of bits 15..10 set, or with band code 2'b11, sets `errFlag`. It issues no `tunePulse` and leaves `bandOut` and `codeOut` unchanged. The legal band codes are 2'b00, 2'b01 and 2'b10.
- R6: A legal word clears `errFlag` in the cycle in which its `tunePulse` is issued.
- R7: The interface mode is taken from `strapSerial` (1 = serial, 0 = parallel) only at reset release. Later changes on the strap have no effect.
- R8: `readyOut` rises after a strobe fall wakes the block. It stays high through loading and through the busy period, and falls back to 0 once processing ends.
- R9: In parallel mode, if the strobe stays low for at least ABORT_CYC cycles while the low byte is awaited, the following strobe rise cancels the transfer. `readyOut` drops to 0, no `tunePulse` is issued, and the outputs keep their values.
- R10: `busyOut` is high for exactly BUSY_CYC cycles per legal command, starting in the cycle of its `tunePulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapSerial | input | 1 | Mode strap: 1 selects serial, 0 selects parallel |
| strobeN | input | 1 | Wake/load strobe; serial chip select |
| parBus | input | 8 | Parallel data; bit 7 is the serial clock and bit 5 the serial data in serial mode |
| readyOut | output | 1 | Handshake: high from wake-up until processing ends |
| tunePulse | output | 1 | One-cycle start for a legal command |
| bandOut | output | 2 | Band code of the last legal command |
| codeOut | output | 8 | Step index of the last legal command |
| errFlag | output | 1 | Sticky error for a rejected command |
| busyOut | output | 1 | Modelled tuning busy period |

## Verification
The hardest state to reach is the half-loaded parallel transfer. To get there, the high byte must already be taken, and the strobe must then sit low well past the abort threshold before it rises. The bench drives this directly with a low phase far longer than the threshold. It then sends a normal parallel command to show that the block has recovered. Malformed serial frames of 15 and 17 bits, and a strap change after reset, are also driven on purpose, because random commands alone would never produce them.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam int CMD_W  = 16;
  localparam int BUS_W  = CMD_W / 2;
  localparam int BAND_W = 2;
  localparam int CODE_W = 8;
  localparam int BAND_LSB = CODE_W;
  localparam int PAD_LSB  = CODE_W + BAND_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SER, ST_PHI, ST_PLO, ST_EVAL, ST_BUSY
  } tcrState_t;

  // control -> datapath
  typedef struct packed {
    logic clrCnt;
    logic shiftEn;
    logic loadHi;
    logic loadLo;
    logic commit;
    logic setErr;
  } tcrCtrl_t;

  // datapath -> control
  typedef struct packed {
    logic modeKnown;
    logic modeSerial;
    logic strobeFall;
    logic strobeRise;
    logic strobeLow;
    logic sclkRise;
    logic frameFull;
    logic wordValid;
  } tcrStat_t;
endpackage

// File: rtl/tcr_sync.sv
module tcr_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tcr_datapath.sv
module tcr_datapath
  import tcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS = CMD_W,
  parameter int SCLK_BIT = 7,
  parameter int MOSI_BIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapSerial,
  input  logic              strobeN,
  input  logic [BUS_W-1:0]  parBus,
  input  tcrCtrl_t          ctrl,
  output tcrStat_t          stat,
  output logic              tunePulse,
  output logic [BAND_W-1:0] bandOut,
  output logic [CODE_W-1:0] codeOut,
  output logic              errFlag
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);

  logic             stbSync, stbPrev;
  logic [BUS_W-1:0] busSync;
  logic             sclkPrev;
  logic             modeSerial, modeKnown;
  logic [CMD_W-1:0] word;
  logic [CNT_W-1:0] bitCnt;

  tcr_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) stbSync_i (
    .clk(clk), .rstN(rstN), .d(strobeN), .q(stbSync));
  tcr_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL({BUS_W{1'b1}})) busSync_i (
    .clk(clk), .rstN(rstN), .d(parBus), .q(busSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbPrev  <= 1'b1;
      sclkPrev <= 1'b1;
    end else begin
      stbPrev  <= stbSync;
      sclkPrev <= busSync[SCLK_BIT];
    end
  end

  // strap is static: captured once on the first edge after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeKnown  <= 1'b0;
      modeSerial <= 1'b0;
    end else if (!modeKnown) begin
      modeKnown  <= 1'b1;
      modeSerial <= strapSerial;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      word   <= '0;
      bitCnt <= '0;
    end else begin
      if (ctrl.clrCnt) bitCnt <= '0;
      else if (ctrl.shiftEn) begin
        word <= {word[CMD_W-2:0], busSync[MOSI_BIT]};
        if (bitCnt != '1) bitCnt <= bitCnt + 1'b1;
      end
      if (ctrl.loadHi) word[CMD_W-1:BUS_W] <= busSync;
      if (ctrl.loadLo) word[BUS_W-1:0]     <= busSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tunePulse <= 1'b0;
      bandOut   <= '0;
      codeOut   <= '0;
      errFlag   <= 1'b0;
    end else begin
      tunePulse <= ctrl.commit;
      if (ctrl.commit) begin
        bandOut <= word[BAND_LSB +: BAND_W];
        codeOut <= word[CODE_W-1:0];
        errFlag <= 1'b0;
      end else if (ctrl.setErr) begin
        errFlag <= 1'b1;
      end
    end
  end

  always_comb begin
    stat.modeKnown  = modeKnown;
    stat.modeSerial = modeSerial;
    stat.strobeFall = !stbSync && stbPrev;
    stat.strobeRise = stbSync && !stbPrev;
    stat.strobeLow  = !stbSync;
    stat.sclkRise   = busSync[SCLK_BIT] && !sclkPrev;
    stat.frameFull  = (bitCnt == CNT_W'(FRAME_BITS));
    stat.wordValid  = (word[CMD_W-1:PAD_LSB] == '0) &&
                      (word[BAND_LSB +: BAND_W] != '1);
  end
endmodule

// File: rtl/tcr_control.sv
module tcr_control
  import tcr_pkg::*;
#(
  parameter int ABORT_CYC = 60,
  parameter int BUSY_CYC = 20
) (
  input  logic     clk,
  input  logic     rstN,
  input  tcrStat_t stat,
  output tcrCtrl_t ctrl,
  output logic     readyOut,
  output logic     busyOut
);
  localparam int LOW_W  = $clog2(ABORT_CYC + 1);
  localparam int BUSY_W = $clog2(BUSY_CYC + 1);

  tcrState_t   state, nxt;
  logic [LOW_W-1:0]  lowCnt;
  logic [BUSY_W-1:0] busyCnt;
  logic        lowLong;

  assign lowLong = (lowCnt >= LOW_W'(ABORT_CYC));

  always_comb begin
    nxt  = state;
    ctrl = '0;
    case (state)
      ST_IDLE: if (stat.strobeFall && stat.modeKnown) begin
        ctrl.clrCnt = 1'b1;
        nxt = stat.modeSerial ? ST_SER : ST_PHI;
      end
      ST_SER: begin
        if (stat.strobeRise) nxt = stat.frameFull ? ST_EVAL : ST_IDLE;
        else if (stat.sclkRise) ctrl.shiftEn = 1'b1;
      end
      ST_PHI: if (stat.strobeRise) begin
        ctrl.loadHi = 1'b1;
        nxt = ST_PLO;
      end
      ST_PLO: if (stat.strobeRise) begin
        if (lowLong) nxt = ST_IDLE;
        else begin
          ctrl.loadLo = 1'b1;
          nxt = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (stat.wordValid) begin
          ctrl.commit = 1'b1;
          nxt = ST_BUSY;
        end else begin
          ctrl.setErr = 1'b1;
          nxt = ST_IDLE;
        end
      end
      ST_BUSY: if (busyCnt == '0) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      lowCnt  <= '0;
      busyCnt <= '0;
    end else begin
      state <= nxt;
      if (!stat.strobeLow) lowCnt <= '0;
      else if (!lowLong)   lowCnt <= lowCnt + 1'b1;
      if (ctrl.commit) busyCnt <= BUSY_W'(BUSY_CYC - 1);
      else if (state == ST_BUSY && busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end
  end

  assign readyOut = (state != ST_IDLE);
  assign busyOut  = (state == ST_BUSY);
endmodule

// File: rtl/tune_cmd_rx.sv
module tune_cmd_rx
  import tcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ABORT_CYC = 60,
  parameter int BUSY_CYC = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapSerial,
  input  logic              strobeN,
  input  logic [BUS_W-1:0]  parBus,
  output logic              readyOut,
  output logic              tunePulse,
  output logic [BAND_W-1:0] bandOut,
  output logic [CODE_W-1:0] codeOut,
  output logic              errFlag,
  output logic              busyOut
);
  tcrCtrl_t ctrl;
  tcrStat_t stat;
  logic     modeSerial, modeKnown;

  tcr_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .strapSerial(strapSerial), .strobeN(strobeN),
    .parBus(parBus), .ctrl(ctrl), .stat(stat), .tunePulse(tunePulse),
    .bandOut(bandOut), .codeOut(codeOut), .errFlag(errFlag));

  tcr_control #(.ABORT_CYC(ABORT_CYC), .BUSY_CYC(BUSY_CYC)) ctl_i (
    .clk(clk), .rstN(rstN), .stat(stat), .ctrl(ctrl),
    .readyOut(readyOut), .busyOut(busyOut));

  assign modeSerial = stat.modeSerial;
  assign modeKnown  = stat.modeKnown;
endmodule

// File: rtl/tune_cmd_rx_chk.sv
module tune_cmd_rx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       readyOut,
  input logic       tunePulse,
  input logic [1:0] bandOut,
  input logic [7:0] codeOut,
  input logic       errFlag,
  input logic       busyOut,
  input logic       modeSerial,
  input logic       modeKnown
);
  AST_TUNE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    tunePulse |=> !tunePulse); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tunePulse |-> ($stable(bandOut) && $stable(codeOut))); // R5
  AST_BAND_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    tunePulse |-> (bandOut != 2'b11)); // R5
  AST_ERR_NO_TUNE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !tunePulse); // R5
  AST_TUNE_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    tunePulse |-> !errFlag); // R6
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    modeKnown |=> ($stable(modeSerial) && modeKnown)); // R7
  AST_BUSY_READY: assert property (@(posedge clk) disable iff (!rstN)
    busyOut |-> readyOut); // R8
  AST_TUNE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    tunePulse |-> busyOut); // R10
endmodule

bind tune_cmd_rx tune_cmd_rx_chk chk_i (
  .clk(clk), .rstN(rstN), .readyOut(readyOut), .tunePulse(tunePulse),
  .bandOut(bandOut), .codeOut(codeOut), .errFlag(errFlag), .busyOut(busyOut),
  .modeSerial(modeSerial), .modeKnown(modeKnown));

// File: tb/tune_cmd_rx_tb_top.sv
module tune_cmd_rx_tb_top;
  localparam int BUSY_CYC = 20;
  localparam int ABORT_CYC = 60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapSerial = 1'b1;
  logic strobeN = 1'b1;
  logic [7:0] parBus = 8'h5F; // serial clock (bit 7) idles low
  logic readyOut, tunePulse, errFlag, busyOut;
  logic [1:0] bandOut;
  logic [7:0] codeOut;

  int checks = 0, fails = 0;
  int pulseCnt = 0, busyCnt = 0;
  int expPulse = 0, expBusy = 0, expBand = 0, expCode = 0, expErr = 0;

  always #2.5 clk = ~clk;

  tune_cmd_rx #(.ABORT_CYC(ABORT_CYC), .BUSY_CYC(BUSY_CYC)) dut_i (
    .clk(clk), .rstN(rstN), .strapSerial(strapSerial), .strobeN(strobeN),
    .parBus(parBus), .readyOut(readyOut), .tunePulse(tunePulse),
    .bandOut(bandOut), .codeOut(codeOut), .errFlag(errFlag), .busyOut(busyOut));

  always @(negedge clk) begin
    if (rstN && tunePulse) pulseCnt++;
    if (rstN && busyOut) busyCnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit legal(input logic [15:0] w);
    return (w[15:10] == 6'd0) && (w[9:8] != 2'b11);
  endfunction

  // reference model update for a command that reached evaluation
  task automatic model(input logic [15:0] w);
    if (legal(w)) begin
      expBand = int'(w[9:8]); expCode = int'(w[7:0]); expErr = 0;
      expPulse++; expBusy += BUSY_CYC;
    end else expErr = 1;
  endtask

  task automatic checkAll(input string req);
    cyc(BUSY_CYC + 30);
    chk({req, " tunePulse count"}, pulseCnt, expPulse);
    chk({req, " bandOut"}, int'(bandOut), expBand);
    chk({req, " codeOut"}, int'(codeOut), expCode);
    chk({req, " errFlag"}, int'(errFlag), expErr);
    chk("R10 busy cycles", busyCnt, expBusy);
    chk("R8 ready low when done", int'(readyOut), 0);
  endtask

  task automatic doReset(input logic strap);
    rstN = 1'b0; strapSerial = strap; strobeN = 1'b1; parBus = 8'h5F;
    cyc(3);
    chk("R1 ready in reset", int'(readyOut), 0);
    rstN = 1'b1;
    cyc(5);
    chk("R1 ready", int'(readyOut), 0);
    chk("R1 tunePulse", int'(tunePulse), 0);
    chk("R1 busy", int'(busyOut), 0);
    chk("R1 err", int'(errFlag), 0);
    chk("R1 band/code", int'({bandOut, codeOut}), 0);
    pulseCnt = 0; busyCnt = 0; expPulse = 0; expBusy = 0;
    expBand = 0; expCode = 0; expErr = 0;
  endtask

  task automatic serialSend(input logic [15:0] w, input int nbits);
    strobeN = 1'b0;
    cyc(20);
    chk("R8 ready after wake", int'(readyOut), 1);
    for (int i = 0; i < nbits; i++) begin
      parBus[5] = (i < 16) ? w[15 - i] : 1'b0;
      cyc(12);
      parBus[7] = 1'b1;
      cyc(12);
      parBus[7] = 1'b0;
    end
    cyc(12);
    strobeN = 1'b1;
    cyc(2);
  endtask

  task automatic parSend(input logic [15:0] w, input bit abortIt);
    strobeN = 1'b0;
    cyc(20);
    chk("R8 ready after wake", int'(readyOut), 1);
    parBus = w[15:8];
    cyc(4);
    strobeN = 1'b1;
    cyc(10);
    strobeN = 1'b0;
    parBus = w[7:0];
    cyc(abortIt ? ABORT_CYC + 40 : 10);
    strobeN = 1'b1;
    cyc(2);
  endtask

  function automatic logic [15:0] randWord();
    logic [15:0] w;
    w = 16'($urandom);
    if (($urandom % 4) != 0) w[15:10] = 6'd0;
    return w;
  endfunction

  initial begin
    logic [15:0] w;
    void'($urandom(32'd20240611));
    doReset(1'b1);

    // serial directed
    serialSend(16'h007D, 16); model(16'h007D); checkAll("R2 serial");
    serialSend(16'h02DC, 16); model(16'h02DC); checkAll("R2 serial");
    serialSend(16'h0300, 16); model(16'h0300); checkAll("R5 band 11");
    serialSend(16'h0117, 16); model(16'h0117); checkAll("R6 err clear");
    serialSend(16'h8042, 16); model(16'h8042); checkAll("R5 pad bits");
    serialSend(16'h0155, 15); checkAll("R3 short frame");
    serialSend(16'h0155, 17); checkAll("R3 long frame");
    serialSend(16'h00FA, 16); model(16'h00FA); checkAll("R6 err clear");

    for (int n = 0; n < 12; n++) begin
      w = randWord();
      serialSend(w, 16); model(w); checkAll("R2 serial random");
    end

    // strap moved after reset: block stays serial
    strapSerial = 1'b0;
    cyc(10);
    serialSend(16'h0201, 16); model(16'h0201); checkAll("R7 strap ignored");

    // parallel mode
    doReset(1'b0);
    parSend(16'h01F9, 1'b0); model(16'h01F9); checkAll("R4 parallel");
    parSend(16'h0400, 1'b0); model(16'h0400); checkAll("R5 parallel pad");
    parSend(16'h0055, 1'b1);
    cyc(8);
    chk("R9 ready dropped on abort", int'(readyOut), 0);
    checkAll("R9 abort");
    parSend(16'h0233, 1'b0); model(16'h0233); checkAll("R9 after abort");

    strapSerial = 1'b1;
    cyc(10);
    parSend(16'h0110, 1'b0); model(16'h0110); checkAll("R7 strap ignored");

    for (int n = 0; n < 12; n++) begin
      w = randWord();
      parSend(w, 1'b0); model(w); checkAll("R4 parallel random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule